// File: doc/BRIEF.md
# PCI Host Bridge Register Block

This block is the CPU-facing register file of an on-chip PCI host controller. A processor reaches it through a plain word-wide port with an address, write data, read data, a write strobe, a read strobe and a ready output. Behind that port are three kinds of storage. The first is a local image of the host's own 64-word configuration header. The second is three window registers: a configuration target address, a memory-window base and an I/O-window base. The third is a data port that does no storing of its own.

Configuration cycles to devices on the bus are indirect. Software loads the target address register, then reads or writes the data port. Each data-port access becomes one 4-byte request on a downstream request/acknowledge port. The CPU port holds ready low until that request is acknowledged.

The block also carries the bus interrupt lines to the interrupt controller. Device number d drives line d modulo the line count, and levels pass through without a register.

Top module: `pcih_regblk`

## Requirements
- R1: Word offsets 0x000 to 0x0FC read and write the local configuration image. Word index is the offset divided by four, and each stored word reads back unchanged.
- R2: After reset, image word 1 (offset 0x004) holds 0x0290_0080 and every other image word holds zero. The low half is the wait-cycle command bit. The high half holds the capability-list, fast back-to-back and medium-select-timing status bits.
- R3: Offset 0x1C0, the configuration target register, stores all 32 bits of a write and reads them back. It resets to zero.
- R4: Offset 0x1C4, the memory base register, keeps bits 31:24 and bit 0 of a write and clears every other bit. It resets to zero.
- R5: Offset 0x1C8, the I/O base register, keeps bits 31:18 and bit 0 of a write, which marks out a 256 KiB window. It resets to 0xFE24_0000.
- R6: A write to the I/O base whose bits 31:18 equal the stored bits 31:18 is dropped entirely, bit 0 included.
- R7: A write to offset 0x220 raises cfg_req with cfg_we=1. cfg_addr equals the target register and cfg_wdata equals the written word. These stay stable until cfg_ack, and cpu_ready is low from the cycle after the strobe until the cycle after cfg_ack.
- R8: A read of offset 0x220 raises cfg_req with cfg_we=0 at the target address. The cfg_rdata value present with cfg_ack is returned on cpu_rdata once cpu_ready rises again.
- R9: Every other offset, and offsets from 0x224 upward, reads as zero and ignores writes. Address bits 1:0 are ignored.
- R10: Strobes presented while cpu_ready is low are ignored.
- R11: irq_out[l] is the OR of irq_in[d] over every device d with d mod 4 = l. With the default four devices this is a straight pass-through, and it is combinational.
- R12: For a local register read, cpu_rdata holds the value from the cycle after the strobe. cpu_ready stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 10 | Byte offset into the register region |
| cpu_wdata | input | 32 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_rdata | output | 32 | Registered read data |
| cpu_ready | output | 1 | High when a new access is accepted |
| cfg_req | output | 1 | Downstream configuration request |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 32 | Configuration target address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Downstream acknowledge |
| cfg_rdata | input | 32 | Downstream read data, valid with cfg_ack |
| irq_in | input | 4 | Per-device interrupt levels |
| irq_out | output | 4 | Interrupt lines to the controller |

## Verification
The bench writes the I/O base twice with the same window bits but a changed bit 0. A design that compares the whole word instead of bits 31:18 would let bit 0 change. It also presents a register write while a data-port read is still waiting for its acknowledge. A design that accepts that write would corrupt the target register, and a design that drops ready too late would also be caught. The bench uses acknowledge delays of zero and several cycles, so a bridge that latches read data on the wrong edge returns stale words. Reads of holes and of offsets past 0x224 expose a decoder that aliases into the image.

// File: rtl/pcih_pkg.sv
package pcih_pkg;
    localparam int DW = 32;

    // word offsets (byte offset / 4) that software relies on
    localparam int WOFS_TARGET = 'h1C0 >> 2;
    localparam int WOFS_MEMWIN = 'h1C4 >> 2;
    localparam int WOFS_IOWIN  = 'h1C8 >> 2;
    localparam int WOFS_PORT   = 'h220 >> 2;

    localparam logic [DW-1:0] MEMWIN_KEEP = 32'hFF00_0001;
    localparam logic [DW-1:0] IOWIN_KEEP  = 32'hFFFC_0001;
    localparam logic [DW-1:0] IOWIN_BASE  = 32'hFFFC_0000;
    localparam logic [DW-1:0] IOWIN_RST   = 32'hFE24_0000;
    localparam logic [DW-1:0] HDR_W1_RST  = 32'h0290_0080;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IMG,
        SEL_TARGET,
        SEL_MEMWIN,
        SEL_IOWIN,
        SEL_PORT
    } sel_e;

    typedef struct packed {
        logic [DW-1:0] target;
        logic [DW-1:0] memwin;
        logic [DW-1:0] iowin;
    } win_t;

    typedef struct packed {
        logic          busy;
        logic          we;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } xfer_t;
endpackage

// File: rtl/pcih_cfg_image.sv
module pcih_cfg_image
    import pcih_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem_d [WORDS];
    logic [DW-1:0] mem_q [WORDS];

    function automatic logic [DW-1:0] rst_word(int i);
        return (i == 1) ? HDR_W1_RST : '0;
    endfunction

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= rst_word(i);
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/pcih_win_regs.sv
module pcih_win_regs
    import pcih_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_target,
    input  logic          wr_memwin,
    input  logic          wr_iowin,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] target_q,
    output logic [DW-1:0] memwin_q,
    output logic [DW-1:0] iowin_q
);
    win_t win_d, win_q;
    logic iowin_moves;

    always_comb begin
        win_d       = win_q;
        iowin_moves = (wdata & IOWIN_BASE) != (win_q.iowin & IOWIN_BASE);
        if (wr_target) begin
            win_d.target = wdata;
        end
        if (wr_memwin) begin
            win_d.memwin = wdata & MEMWIN_KEEP;
        end
        if (wr_iowin && iowin_moves) begin
            win_d.iowin = wdata & IOWIN_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '{target: '0, memwin: '0, iowin: IOWIN_RST};
        end else begin
            win_q <= win_d;
        end
    end

    assign target_q = win_q.target;
    assign memwin_q = win_q.memwin;
    assign iowin_q  = win_q.iowin;
endmodule

// File: rtl/pcih_cfg_xfer.sv
module pcih_cfg_xfer
    import pcih_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [DW-1:0] start_addr,
    input  logic [DW-1:0] start_data,
    input  logic          cfg_ack,
    output logic          busy,
    output logic          done,
    output logic          cfg_req,
    output logic          cfg_we,
    output logic [DW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_wdata
);
    xfer_t x_d, x_q;

    always_comb begin
        x_d = x_q;
        if (x_q.busy) begin
            if (cfg_ack) begin
                x_d.busy = 1'b0;
            end
        end else if (start) begin
            x_d.busy = 1'b1;
            x_d.we   = start_we;
            x_d.addr = start_addr;
            x_d.data = start_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
        end else begin
            x_q <= x_d;
        end
    end

    assign busy      = x_q.busy;
    assign done      = x_q.busy && cfg_ack;
    assign cfg_req   = x_q.busy;
    assign cfg_we    = x_q.we;
    assign cfg_addr  = x_q.addr;
    assign cfg_wdata = x_q.data;
endmodule

// File: rtl/pcih_irq_route.sv
module pcih_irq_route #(
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4
) (
    input  logic [NUM_DEV-1:0]   irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    function automatic logic [NUM_DEV-1:0] line_mask(int line);
        logic [NUM_DEV-1:0] m;
        m = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if ((d % NUM_LINES) == line) begin
                m[d] = 1'b1;
            end
        end
        return m;
    endfunction

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam logic [NUM_DEV-1:0] MASK = line_mask(l);
        assign irq_out[l] = |(irq_in & MASK);
    end
endmodule

// File: rtl/pcih_regblk.sv
module pcih_regblk
    import pcih_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int IMG_WORDS = 64,
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DW-1:0]        cpu_wdata,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    output logic [DW-1:0]        cpu_rdata,
    output logic                 cpu_ready,
    output logic                 cfg_req,
    output logic                 cfg_we,
    output logic [DW-1:0]        cfg_addr,
    output logic [DW-1:0]        cfg_wdata,
    input  logic                 cfg_ack,
    input  logic [DW-1:0]        cfg_rdata,
    input  logic [NUM_DEV-1:0]   irq_in,
    output logic [NUM_LINES-1:0] irq_out
);
    localparam int IDX_W = $clog2(IMG_WORDS);

    logic [ADDR_W-1:0] word_ofs;
    sel_e              sel;
    logic              accept, acc_wr, acc_rd;
    logic [DW-1:0]     img_rdata, target_q, memwin_q, iowin_q;
    logic              busy, done;
    logic [DW-1:0]     rdata_d, rdata_q;

    // address decode; byte lane bits are shifted out
    always_comb begin
        word_ofs = cpu_addr >> 2;
        if (word_ofs < ADDR_W'(IMG_WORDS))         sel = SEL_IMG;
        else if (word_ofs == ADDR_W'(WOFS_TARGET)) sel = SEL_TARGET;
        else if (word_ofs == ADDR_W'(WOFS_MEMWIN)) sel = SEL_MEMWIN;
        else if (word_ofs == ADDR_W'(WOFS_IOWIN))  sel = SEL_IOWIN;
        else if (word_ofs == ADDR_W'(WOFS_PORT))   sel = SEL_PORT;
        else                                       sel = SEL_NONE;
    end

    assign accept = !busy && (cpu_wr || cpu_rd);
    assign acc_wr = !busy && cpu_wr;
    assign acc_rd = !busy && cpu_rd && !cpu_wr;

    pcih_cfg_image #(.WORDS(IMG_WORDS)) u_img (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (acc_wr && sel == SEL_IMG),
        .idx   (word_ofs[IDX_W-1:0]),
        .wdata (cpu_wdata),
        .rdata (img_rdata)
    );

    pcih_win_regs u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_target (acc_wr && sel == SEL_TARGET),
        .wr_memwin (acc_wr && sel == SEL_MEMWIN),
        .wr_iowin  (acc_wr && sel == SEL_IOWIN),
        .wdata     (cpu_wdata),
        .target_q  (target_q),
        .memwin_q  (memwin_q),
        .iowin_q   (iowin_q)
    );

    pcih_cfg_xfer u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept && sel == SEL_PORT),
        .start_we   (acc_wr),
        .start_addr (target_q),
        .start_data (cpu_wdata),
        .cfg_ack    (cfg_ack),
        .busy       (busy),
        .done       (done),
        .cfg_req    (cfg_req),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata)
    );

    pcih_irq_route #(.NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES)) u_irq (
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );

    // read data register
    always_comb begin
        rdata_d = rdata_q;
        if (done && !cfg_we) begin
            rdata_d = cfg_rdata;
        end else if (acc_rd) begin
            unique case (sel)
                SEL_IMG:    rdata_d = img_rdata;
                SEL_TARGET: rdata_d = target_q;
                SEL_MEMWIN: rdata_d = memwin_q;
                SEL_IOWIN:  rdata_d = iowin_q;
                SEL_PORT:   rdata_d = rdata_q;
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign cpu_rdata = rdata_q;
    assign cpu_ready = !busy;
endmodule

// File: rtl/pcih_regblk_chk.sv
module pcih_regblk_chk
    import pcih_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic [DW-1:0]        cpu_wdata,
    input logic                 cpu_wr,
    input logic                 cpu_rd,
    input logic [DW-1:0]        cpu_rdata,
    input logic                 cpu_ready,
    input logic                 cfg_req,
    input logic                 cfg_we,
    input logic [DW-1:0]        cfg_addr,
    input logic [DW-1:0]        cfg_wdata,
    input logic                 cfg_ack,
    input logic [NUM_DEV-1:0]   irq_in,
    input logic [NUM_LINES-1:0] irq_out,
    input logic [DW-1:0]        iowin,
    input logic [DW-1:0]        target
);
    logic [ADDR_W-1:0] wofs;
    logic              port_hit, hole_hit, iowin_same;
    assign wofs       = cpu_addr >> 2;
    assign port_hit   = wofs == ADDR_W'(WOFS_PORT);
    assign hole_hit   = (wofs >= ADDR_W'(64)) && (wofs != ADDR_W'(WOFS_TARGET)) &&
                        (wofs != ADDR_W'(WOFS_MEMWIN)) && (wofs != ADDR_W'(WOFS_IOWIN)) && !port_hit;
    assign iowin_same = (cpu_wdata[31:18] == iowin[31:18]);

    // R7: a request only starts from an accepted data-port access
    p_req_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> $past(cpu_ready && (cpu_wr || cpu_rd) && port_hit));

    // R7: request fields hold while waiting
    p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_we)));

    // R7: ready is low while a request is outstanding
    p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !cpu_ready);

    // R6: same-window write to the I/O base changes nothing
    p_iowin_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_wr && wofs == ADDR_W'(WOFS_IOWIN) && iowin_same) |=> $stable(iowin));

    // R9: holes read as zero
    p_hole_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_rd && !cpu_wr && hole_hit) |=> (cpu_rdata == '0));

    // R10: strobes while busy leave the target register alone
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_ready && cpu_wr) |=> $stable(target));

    // R11: default routing is a pass-through
    if (NUM_DEV == NUM_LINES) begin : g_pass
        p_irq_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out == NUM_LINES'(irq_in));
    end
endmodule

bind pcih_regblk pcih_regblk_chk #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata),
    .cpu_ready (cpu_ready),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_ack   (cfg_ack),
    .irq_in    (irq_in),
    .irq_out   (irq_out),
    .iowin     (iowin_q),
    .target    (target_q)
);

// File: tb/pcih_regblk_bench.sv
module pcih_regblk_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic [3:0]  irq_in = '0;
    logic [3:0]  irq_out;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [31:0] m_img [64];
    logic [31:0] m_target, m_memwin, m_iowin;
    bit          exp_pend = 0;
    bit          exp_we;
    logic [31:0] exp_addr, exp_data;
    int          ack_delay = 0, dly_ctr = 0;

    always #4 clk = ~clk;

    pcih_regblk u_pcih_regblk (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .irq_in(irq_in), .irq_out(irq_out)
    );

    function automatic logic [31:0] resp_word(logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [9:0] a);
        int w = int'(a >> 2);
        if (w < 64) return m_img[w];
        if (w == ('h1C0 >> 2)) return m_target;
        if (w == ('h1C4 >> 2)) return m_memwin;
        if (w == ('h1C8 >> 2)) return m_iowin;
        return 32'h0;
    endfunction

    // downstream responder and request checker
    always @(negedge clk) begin
        if (cfg_ack) begin
            cfg_ack = 1'b0;
        end else if (cfg_req) begin
            if (!exp_pend) begin
                chk("R10 unexpected request", 32'(cfg_req), 32'h0);
            end else if (dly_ctr == 0) begin
                chk("R7/R8 cfg_we", 32'(cfg_we), 32'(exp_we));
                chk("R7/R8 cfg_addr", cfg_addr, exp_addr);
                if (exp_we) chk("R7 cfg_wdata", cfg_wdata, exp_data);
                cfg_rdata = resp_word(cfg_addr);
                cfg_ack   = 1'b1;
                exp_pend  = 0;
            end else begin
                dly_ctr--;
            end
        end
    end

    // per-clock comparison of interrupt routing (R11)
    always @(negedge clk) begin
        if (rst_n && !finished) chk("R11 irq routing", 32'(irq_out), 32'(irq_in));
    end

    task automatic wait_ready(string req);
        int guard = 0;
        @(negedge clk);
        chk({req, " ready low after strobe"}, 32'(cpu_ready), 32'h0);
        while (!cpu_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic cpu_write(logic [9:0] a, logic [31:0] d);
        int w = int'(a >> 2);
        if (w == ('h220 >> 2)) begin
            exp_pend = 1; exp_we = 1; exp_addr = m_target; exp_data = d; dly_ctr = ack_delay;
        end
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(posedge clk);
        #1 cpu_wr = 1'b0;
        if (w < 64) m_img[w] = d;
        else if (w == ('h1C0 >> 2)) m_target = d;
        else if (w == ('h1C4 >> 2)) m_memwin = d & 32'hFF00_0001;
        else if (w == ('h1C8 >> 2)) begin
            if (d[31:18] != m_iowin[31:18]) m_iowin = d & 32'hFFFC_0001;
        end else if (w == ('h220 >> 2)) wait_ready("R7");
    endtask

    task automatic cpu_read(string req, logic [9:0] a);
        int w = int'(a >> 2);
        logic [31:0] exp;
        if (w == ('h220 >> 2)) begin
            exp_pend = 1; exp_we = 0; exp_addr = m_target; dly_ctr = ack_delay;
            exp = resp_word(m_target);
        end else begin
            exp = model_read(a);
        end
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(posedge clk);
        #1 cpu_rd = 1'b0;
        if (w == ('h220 >> 2)) begin
            wait_ready("R8");
        end else begin
            @(negedge clk);
            chk({req, " R12 ready during local read"}, 32'(cpu_ready), 32'h1);
        end
        chk(req, cpu_rdata, exp);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_img[i] = (i == 1) ? 32'h0290_0080 : 32'h0;
        m_target = '0; m_memwin = '0; m_iowin = 32'hFE24_0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset ready", 32'(cpu_ready), 32'h1);
        chk("R7 reset req", 32'(cfg_req), 32'h0);

        // R2 reset image, R3/R4/R5 reset windows
        cpu_read("R2 image word0", 10'h000);
        cpu_read("R2 image word1", 10'h004);
        cpu_read("R2 image word63", 10'h0FC);
        cpu_read("R3 target reset", 10'h1C0);
        cpu_read("R4 memwin reset", 10'h1C4);
        cpu_read("R5 iowin reset", 10'h1C8);

        // R1 image read/write, varied patterns
        cpu_write(10'h000, 32'hDEAD_BEEF);
        cpu_write(10'h0FC, 32'h1234_5678);
        cpu_write(10'h044, 32'hA5A5_5A5A);
        cpu_read("R1 image word0", 10'h000);
        cpu_read("R1 image word63", 10'h0FC);
        cpu_read("R1 image word17", 10'h044);
        cpu_read("R9 lane bits ignored", 10'h047);

        // R3 target, R4 memwin mask
        cpu_write(10'h1C0, 32'h8000_0A10);
        cpu_read("R3 target readback", 10'h1C0);
        cpu_write(10'h1C4, 32'hFFFF_FFFF);
        cpu_read("R4 memwin mask", 10'h1C4);

        // R5 iowin relocate, R6 same-window drop
        cpu_write(10'h1C8, 32'h1234_5677);
        cpu_read("R5 iowin relocate", 10'h1C8);
        cpu_write(10'h1C8, 32'h1234_0000);
        cpu_read("R6 iowin same window dropped", 10'h1C8);
        cpu_write(10'h1C8, 32'hFFFF_FFFE);
        cpu_read("R5 iowin keep mask", 10'h1C8);

        // R9 holes and out-of-range
        cpu_write(10'h100, 32'hFFFF_FFFF);
        cpu_write(10'h224, 32'hFFFF_FFFF);
        cpu_write(10'h3FC, 32'hFFFF_FFFF);
        cpu_read("R9 hole 0x100 zero", 10'h100);
        cpu_read("R9 past end zero", 10'h224);
        cpu_read("R9 top zero", 10'h3FC);
        cpu_read("R9 image untouched", 10'h000);
        cpu_read("R9 target untouched", 10'h1C0);

        // R7/R8 data port with zero and long ack delays
        ack_delay = 0;
        cpu_write(10'h220, 32'hCAFE_0001);
        cpu_read("R8 data port read delay0", 10'h220);
        ack_delay = 5;
        cpu_write(10'h1C0, 32'h0000_0808);
        cpu_write(10'h220, 32'hCAFE_0002);
        cpu_read("R8 data port read delay5", 10'h220);

        // R10: write during busy read is ignored
        ack_delay = 6;
        exp_pend = 1; exp_we = 0; exp_addr = m_target; dly_ctr = ack_delay;
        @(negedge clk);
        cpu_addr = 10'h220; cpu_rd = 1'b1;
        @(posedge clk);
        #1 cpu_rd = 1'b0;
        @(negedge clk);
        cpu_addr = 10'h1C0; cpu_wdata = 32'hBAD0_BAD0; cpu_wr = 1'b1;
        @(posedge clk);
        #1 cpu_wr = 1'b0;
        while (!cpu_ready) @(negedge clk);
        chk("R10 read result during busy write", cpu_rdata, resp_word(32'h0000_0808));
        cpu_read("R10 target unchanged", 10'h1C0);

        // R11 irq patterns
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            irq_in = 4'(p);
        end
        @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule